// File: doc/BRIEF.md
# Useful-Word Fetch Mask Predictor

This block decides, one cycle ahead of an instruction cache access, which instruction words of the upcoming line are worth reading. The cache gates each word of the line separately, so every word left disabled saves array energy. The block drives one enable bit per 32-bit word. The line holds 4 or 8 words.

Two estimates are combined. The first applies when the next fetch is a redirect from the branch target buffer. The word offset of that target marks where useful words begin, and everything before it is skipped. The second is a small direct-mapped table, selected by the low bits of the line address. It remembers the slot of the last taken branch seen in that line, and everything after that slot is skipped. The final enable vector is the bitwise AND of the two. An empty table entry, or a fetch that is not a redirect, leaves its half of the estimate at all ones, so an unknown line is fetched in full. Branch resolution trains the table in the same cycle that the direction predictor is updated. A fetch misprediction that needed a word the mask had turned off produces a one-cycle refetch with the whole line enabled.

Top module: `fetch_mask_pred`

## Requirements
- R1: After reset `mask_valid_o` and `refetch_o` are 0, `mask_o` is all ones, and every table entry is empty, so a non-redirect prediction for any line yields an all-ones mask.
- R2: A prediction requested with `pred_valid_i` in cycle N (and no `mispred_i`) produces `mask_valid_o`=1 with its mask in cycle N+1 only. Back-to-back requests give back-to-back results.
- R3: With `pred_is_target_i`=1 and word offset `pred_tgt_off_i`=k, mask bits k through WORDS-1 may be set and bits below k are 0. Bit i of `mask_o` enables word i of the line.
- R4: When the selected entry holds branch slot s, mask bits 0 through s may be set and bits above s are 0.
- R5: When both estimates apply, `mask_o` is their bitwise AND. A target offset beyond the stored slot gives an all-zero mask.
- R6: A resolved taken branch (`upd_valid_i`=1, `upd_taken_i`=1) writes slot `upd_slot_i` into entry `upd_idx_i` and marks it full, replacing any older slot. Other entries are not changed.
- R7: A resolved not-taken branch empties its entry only if the entry is full and holds the same slot. Otherwise the entry is unchanged.
- R8: A prediction and an update to the same entry in the same cycle see the updated entry.
- R9: `mispred_i` in cycle N gives `refetch_o`=1, `mask_valid_o`=1 and an all-ones `mask_o` in cycle N+1 for that cycle only. A prediction requested in cycle N is dropped.
- R10: Whenever `mask_valid_o` is 0, `mask_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid_i | input | 1 | Request a mask for the next line |
| pred_idx_i | input | IDX_W | Low line-address bits of the next line |
| pred_is_target_i | input | 1 | Next fetch is a predicted branch target |
| pred_tgt_off_i | input | SLOT_W | Word offset of that target in its line |
| upd_valid_i | input | 1 | Branch resolution event |
| upd_idx_i | input | IDX_W | Low line-address bits of the resolved branch's line |
| upd_slot_i | input | SLOT_W | Word slot of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction, 1 = taken |
| mispred_i | input | 1 | A needed word was not enabled; request refetch |
| mask_valid_o | output | 1 | `mask_o` carries a result this cycle |
| mask_o | output | WORDS | Per-word enable vector |
| refetch_o | output | 1 | Current result is a full-line refetch |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a table update and a prediction that reads the same entry. The bench drives a taken update and a prediction to one index on the same edge, then does the same with an invalidating not-taken update, and compares the mask against the entry's new content. The second pair is a misprediction and a prediction request arriving together. There the bench expects one all-ones refetch cycle and no result for the dropped request in the cycle after it.

// File: rtl/fmp_pkg.sv
package fmp_pkg;

    // Kind of result held in the output register
    typedef enum logic [1:0] {
        OUT_IDLE    = 2'd0,
        OUT_PREDICT = 2'd1,
        OUT_REFETCH = 2'd2
    } out_kind_e;

    // Bits needed to number the words of a line
    function automatic int slot_bits(input int words);
        return (words <= 2) ? 1 : $clog2(words);
    endfunction

endpackage

// File: rtl/fmp_end_table.sv
module fmp_end_table #(
    parameter int WORDS   = 8,
    parameter int ENTRIES = 64,
    localparam int SLOT_W = fmp_pkg::slot_bits(WORDS),
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              rd_full_o,
    output logic [SLOT_W-1:0] rd_slot_o,
    input  logic              wr_valid_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  logic              wr_taken_i
);

    typedef struct packed {
        logic              full;
        logic [SLOT_W-1:0] slot;
    } entry_t;

    entry_t tbl_q [ENTRIES];
    entry_t tbl_d [ENTRIES];
    entry_t rd_ent;

    // Next-state of the table: train on resolution events
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            tbl_d[e] = tbl_q[e];
        end
        if (wr_valid_i) begin
            if (wr_taken_i) begin
                tbl_d[wr_idx_i].full = 1'b1;
                tbl_d[wr_idx_i].slot = wr_slot_i;
            end else if (tbl_q[wr_idx_i].full &&
                         (tbl_q[wr_idx_i].slot == wr_slot_i)) begin
                tbl_d[wr_idx_i].full = 1'b0;
            end
        end
    end

    // Read after this cycle's update, so a colliding prediction sees it
    always_comb begin
        rd_ent    = tbl_d[rd_idx_i];
        rd_full_o = rd_ent.full;
        rd_slot_o = rd_ent.slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                tbl_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                tbl_q[e] <= tbl_d[e];
            end
        end
    end

endmodule

// File: rtl/fmp_mask_gen.sv
module fmp_mask_gen #(
    parameter int WORDS   = 8,
    localparam int SLOT_W = fmp_pkg::slot_bits(WORDS)
) (
    input  logic              is_target_i,
    input  logic [SLOT_W-1:0] tgt_off_i,
    input  logic              end_full_i,
    input  logic [SLOT_W-1:0] end_slot_i,
    output logic [WORDS-1:0]  start_mask_o,
    output logic [WORDS-1:0]  end_mask_o,
    output logic [WORDS-1:0]  mask_o
);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam logic [SLOT_W-1:0] POS = SLOT_W'(g);
        // Word g lies at or after the predicted entry point
        assign start_mask_o[g] = !is_target_i || (POS >= tgt_off_i);
        // Word g lies at or before the predicted taken branch
        assign end_mask_o[g]   = !end_full_i || (POS <= end_slot_i);
        assign mask_o[g]       = start_mask_o[g] & end_mask_o[g];
    end

endmodule

// File: rtl/fetch_mask_pred.sv
module fetch_mask_pred #(
    parameter int WORDS   = 8,
    parameter int ENTRIES = 64,
    localparam int SLOT_W = fmp_pkg::slot_bits(WORDS),
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid_i,
    input  logic [IDX_W-1:0]  pred_idx_i,
    input  logic              pred_is_target_i,
    input  logic [SLOT_W-1:0] pred_tgt_off_i,
    input  logic              upd_valid_i,
    input  logic [IDX_W-1:0]  upd_idx_i,
    input  logic [SLOT_W-1:0] upd_slot_i,
    input  logic              upd_taken_i,
    input  logic              mispred_i,
    output logic              mask_valid_o,
    output logic [WORDS-1:0]  mask_o,
    output logic              refetch_o
);

    import fmp_pkg::*;

    localparam logic [WORDS-1:0] FULL_LINE = '1;

    typedef struct packed {
        out_kind_e        kind;
        logic [WORDS-1:0] mask;
    } out_t;

    logic              end_full;
    logic [SLOT_W-1:0] end_slot;
    logic [WORDS-1:0]  start_mask;
    logic [WORDS-1:0]  end_mask;
    logic [WORDS-1:0]  comb_mask;
    out_t              out_d;
    out_t              out_q;

    fmp_end_table #(
        .WORDS   (WORDS),
        .ENTRIES (ENTRIES)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx_i   (pred_idx_i),
        .rd_full_o  (end_full),
        .rd_slot_o  (end_slot),
        .wr_valid_i (upd_valid_i),
        .wr_idx_i   (upd_idx_i),
        .wr_slot_i  (upd_slot_i),
        .wr_taken_i (upd_taken_i)
    );

    fmp_mask_gen #(
        .WORDS (WORDS)
    ) u_gen (
        .is_target_i  (pred_is_target_i),
        .tgt_off_i    (pred_tgt_off_i),
        .end_full_i   (end_full),
        .end_slot_i   (end_slot),
        .start_mask_o (start_mask),
        .end_mask_o   (end_mask),
        .mask_o       (comb_mask)
    );

    // Output selection: refetch overrides a prediction in the same cycle
    always_comb begin
        out_d.kind = OUT_IDLE;
        out_d.mask = FULL_LINE;
        if (mispred_i) begin
            out_d.kind = OUT_REFETCH;
        end else if (pred_valid_i) begin
            out_d.kind = OUT_PREDICT;
            out_d.mask = comb_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.kind <= OUT_IDLE;
            out_q.mask <= FULL_LINE;
        end else begin
            out_q <= out_d;
        end
    end

    assign mask_valid_o = (out_q.kind != OUT_IDLE);
    assign refetch_o    = (out_q.kind == OUT_REFETCH);
    assign mask_o       = out_q.mask;

endmodule

// File: rtl/fmp_checker.sv
module fmp_checker #(
    parameter int WORDS  = 8,
    parameter int SLOT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pred_valid_i,
    input logic              pred_is_target_i,
    input logic [SLOT_W-1:0] pred_tgt_off_i,
    input logic              mispred_i,
    input logic              mask_valid_o,
    input logic [WORDS-1:0]  mask_o,
    input logic              refetch_o
);

    function automatic logic [WORDS-1:0] below(input logic [SLOT_W-1:0] off);
        logic [WORDS-1:0] m;
        for (int i = 0; i < WORDS; i++) begin
            m[i] = (SLOT_W'(i) < off);
        end
        return m;
    endfunction

    // R2: an accepted request yields a result on the next cycle
    a_r2_result_next: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid_i && !mispred_i) |=> (mask_valid_o && !refetch_o));

    // R3: words before a redirect target are never enabled
    a_r3_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid_i && pred_is_target_i && !mispred_i)
        |=> ((mask_o & below($past(pred_tgt_off_i))) == '0));

    // R9: a misprediction gives a full-line refetch next cycle
    a_r9_refetch_full: assert property (@(posedge clk) disable iff (!rst_n)
        mispred_i |=> (refetch_o && mask_valid_o && (mask_o == '1)));

    // R9: a refetch only follows a misprediction
    a_r9_refetch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        refetch_o |-> $past(mispred_i));

    // R10: idle output is a full-line mask
    a_r10_idle_full: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_valid_o |-> (mask_o == '1));

    // R2: nothing requested, nothing produced
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_valid_i && !mispred_i) |=> !mask_valid_o);

endmodule

bind fetch_mask_pred fmp_checker #(
    .WORDS  (WORDS),
    .SLOT_W (SLOT_W)
) u_fmp_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .pred_valid_i     (pred_valid_i),
    .pred_is_target_i (pred_is_target_i),
    .pred_tgt_off_i   (pred_tgt_off_i),
    .mispred_i        (mispred_i),
    .mask_valid_o     (mask_valid_o),
    .mask_o           (mask_o),
    .refetch_o        (refetch_o)
);

// File: tb/tb_fetch_mask_pred.sv
module tb_fetch_mask_pred;

    localparam int WORDS   = 8;
    localparam int ENTRIES = 64;
    localparam int SLOT_W  = 3;
    localparam int IDX_W   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pred_valid_i = 1'b0;
    logic [IDX_W-1:0]  pred_idx_i = '0;
    logic              pred_is_target_i = 1'b0;
    logic [SLOT_W-1:0] pred_tgt_off_i = '0;
    logic              upd_valid_i = 1'b0;
    logic [IDX_W-1:0]  upd_idx_i = '0;
    logic [SLOT_W-1:0] upd_slot_i = '0;
    logic              upd_taken_i = 1'b0;
    logic              mispred_i = 1'b0;
    logic              mask_valid_o;
    logic [WORDS-1:0]  mask_o;
    logic              refetch_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fetch_mask_pred #(.WORDS(WORDS), .ENTRIES(ENTRIES)) dut (
        .clk(clk), .rst_n(rst_n),
        .pred_valid_i(pred_valid_i), .pred_idx_i(pred_idx_i),
        .pred_is_target_i(pred_is_target_i), .pred_tgt_off_i(pred_tgt_off_i),
        .upd_valid_i(upd_valid_i), .upd_idx_i(upd_idx_i),
        .upd_slot_i(upd_slot_i), .upd_taken_i(upd_taken_i),
        .mispred_i(mispred_i),
        .mask_valid_o(mask_valid_o), .mask_o(mask_o), .refetch_o(refetch_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one prediction request; result checked one edge later
    task automatic predict(input string req, input int idx, input bit tgt,
                           input int off, input logic [7:0] exp);
        pred_valid_i = 1'b1; pred_idx_i = IDX_W'(idx);
        pred_is_target_i = tgt; pred_tgt_off_i = SLOT_W'(off);
        @(negedge clk);
        pred_valid_i = 1'b0; pred_is_target_i = 1'b0;
        chk({req, " valid"}, 32'(mask_valid_o), 32'd1);
        chk({req, " mask"}, 32'(mask_o), 32'(exp));
    endtask

    task automatic update(input int idx, input int slot, input bit taken);
        upd_valid_i = 1'b1; upd_idx_i = IDX_W'(idx);
        upd_slot_i = SLOT_W'(slot); upd_taken_i = taken;
        @(negedge clk);
        upd_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(mask_valid_o), 32'd0);
        chk("R1 refetch", 32'(refetch_o), 32'd0);
        chk("R1 mask", 32'(mask_o), 32'hFF);
        predict("R1 empty entry", 5, 0, 0, 8'hFF);
        predict("R1 empty entry 2", 63, 0, 0, 8'hFF);
    endtask

    task automatic t_idle();
        @(negedge clk);
        chk("R10 idle valid", 32'(mask_valid_o), 32'd0);
        chk("R10 idle mask", 32'(mask_o), 32'hFF);
    endtask

    task automatic t_start();
        predict("R3 off2", 9, 1, 2, 8'hFC);
        predict("R3 off7", 9, 1, 7, 8'h80);
        predict("R3 off0", 9, 1, 0, 8'hFF);
    endtask

    task automatic t_end();
        update(5, 3, 1);
        predict("R4 slot3", 5, 0, 0, 8'h0F);
        update(6, 0, 1);
        predict("R4 slot0", 6, 0, 0, 8'h01);
    endtask

    task automatic t_and();
        predict("R5 off1 slot3", 5, 1, 1, 8'h0E);
        predict("R5 off3 slot3", 5, 1, 3, 8'h08);
        predict("R5 empty", 5, 1, 5, 8'h00);
    endtask

    task automatic t_overwrite();
        update(5, 6, 1);
        predict("R6 replaced", 5, 0, 0, 8'h7F);
        predict("R6 neighbour", 6, 0, 0, 8'h01);
        predict("R6 untouched", 4, 0, 0, 8'hFF);
    endtask

    task automatic t_invalidate();
        update(5, 2, 0);
        predict("R7 other slot kept", 5, 0, 0, 8'h7F);
        update(7, 2, 0);
        predict("R7 empty stays empty", 7, 0, 0, 8'hFF);
        update(5, 6, 0);
        predict("R7 match emptied", 5, 0, 0, 8'hFF);
    endtask

    task automatic t_collide();
        upd_valid_i = 1'b1; upd_idx_i = 6'd12; upd_slot_i = 3'd1; upd_taken_i = 1'b1;
        predict("R8 same-cycle write", 12, 0, 0, 8'h03);
        upd_valid_i = 1'b0;
        upd_valid_i = 1'b1; upd_idx_i = 6'd12; upd_slot_i = 3'd1; upd_taken_i = 1'b0;
        predict("R8 same-cycle clear", 12, 0, 0, 8'hFF);
        upd_valid_i = 1'b0;
    endtask

    task automatic t_b2b();
        update(20, 4, 1);
        pred_valid_i = 1'b1; pred_idx_i = 6'd20; pred_is_target_i = 1'b0;
        @(negedge clk);
        chk("R2 first", 32'(mask_o), 32'h1F);
        pred_idx_i = 6'd20; pred_is_target_i = 1'b1; pred_tgt_off_i = 3'd2;
        @(negedge clk);
        pred_valid_i = 1'b0; pred_is_target_i = 1'b0;
        chk("R2 second valid", 32'(mask_valid_o), 32'd1);
        chk("R2 second", 32'(mask_o), 32'h1C);
        @(negedge clk);
        chk("R2 drop after", 32'(mask_valid_o), 32'd0);
    endtask

    task automatic t_refetch();
        update(30, 1, 1);
        mispred_i = 1'b1;
        pred_valid_i = 1'b1; pred_idx_i = 6'd30;
        @(negedge clk);
        mispred_i = 1'b0; pred_valid_i = 1'b0;
        chk("R9 refetch", 32'(refetch_o), 32'd1);
        chk("R9 valid", 32'(mask_valid_o), 32'd1);
        chk("R9 mask", 32'(mask_o), 32'hFF);
        @(negedge clk);
        chk("R9 one cycle", 32'(refetch_o), 32'd0);
        chk("R9 pred dropped", 32'(mask_valid_o), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_start();
        t_end();
        t_and();
        t_overwrite();
        t_invalidate();
        t_collide();
        t_b2b();
        t_refetch();
        t_idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule